// File: doc/BRIEF.md
# External Memory Bus Controller

This block takes single read and write requests from a processor-side port and plays each one out on an external asynchronous memory bus. It decodes the request address into either the PROM area or one of several RAM banks. It then drives the address lines, the chip selects, the output enables, the read indicator, the write strobe and the per-byte write strobes. The external device stretches any access by holding an active-low bus-ready input high.

Each access has two phases. The setup phase drives the address, the selects and any write data. The strobe phase adds the read enables or the write strobes and repeats until bus-ready is seen low. In that final strobe cycle the controller pulses a done flag and presents the read data. Configuration inputs mark each area as 8-bit wide, which puts it on the top byte lane only. They also mark an area as EDAC-protected, in which case a write drives an 8-bit check-bit bus. The low seven check bits come with the request, and bit 7 comes from a configuration input.

The data and check-bit buses appear as separate output, input and output-enable signals. An enclosing pad ring builds the tristate pins from them.

Top module: `membus_ctrl`

## Requirements
- R1: `reqReady` is high exactly when the controller is idle. A request is accepted in a cycle where `reqValid` and `reqReady` are both high, and `reqReady` is low from the next cycle until the access completes.
- R2: An accepted request spends one setup cycle and then one or more strobe cycles. A strobe cycle with `busRdyN` high is followed by another strobe cycle. A strobe cycle with `busRdyN` low raises `rspDone` in that cycle, and the controller is idle in the following cycle.
- R3: In both phases of a read, `oeN` is low and `readOut` is high, and `memDataOe` stays low. In the done cycle, `rspData` carries `memDataIn`.
- R4: On a write, `memDataOe` is high and `memDataOut` carries the write data through both phases. `writeN` is low only in strobe cycles, and `oeN` stays high.
- R5: The PROM area is request addresses with bits 31:29 = 000. `promSelN[0]` is low for addresses with bit 28 = 0, and `promSelN[1]` is low for addresses with bit 28 = 1. Selects are low only during setup and strobe cycles.
- R6: The RAM area is addresses with bits 31:29 = 010, and the bank number is address bits 26:24. For banks 0 to 4, `ramSelN[bank]` is low during the access, and on reads `ramOeN[bank]` is low as well. A bank number of 5 or more asserts no select, but the access still completes.
- R7: Byte strobes are big-endian and active low. `byteWeN[i]` goes low in write strobe cycles when `reqBe[i]` was set. Lane 0 is data bits 31:24, lane 1 is bits 23:16, lane 2 is bits 15:8 and lane 3 is bits 7:0.
- R8: In an area flagged 8-bit (`prom8Bit`, or `ram8Bit[bank]`), a write lowers only `byteWeN[0]`, and does so if any `reqBe` bit is set. A read returns `memDataIn[31:24]` in `rspData[31:24]`, with zeros below.
- R9: `chkOe` is high during both phases of a write to an area flagged EDAC (`promEdac`, or `ramEdac[bank]`), and low otherwise. `chkOut` is {`chkBit7`, request check code}.
- R10: `memAddr` shows bits 27:0 of the last accepted request address. It keeps that value while idle.
- R11: After reset the controller is idle. All selects, enables and strobes are inactive, `readOut` is 0, both output enables are 0 and `memAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, bit 0 = bits 31:24 |
| reqCheck | input | 7 | Check code for writes |
| rspDone | output | 1 | Access completes this cycle |
| rspData | output | 32 | Read data, valid with rspDone |
| prom8Bit | input | 1 | PROM area is 8-bit |
| promEdac | input | 1 | PROM area is EDAC-protected |
| ram8Bit | input | 5 | Per-bank 8-bit flag |
| ramEdac | input | 5 | Per-bank EDAC flag |
| chkBit7 | input | 1 | Value for check bit 7 |
| busRdyN | input | 1 | Bus ready, active low |
| memAddr | output | 28 | Address bus |
| memDataOut | output | 32 | Data bus, outgoing value |
| memDataIn | input | 32 | Data bus, incoming value |
| memDataOe | output | 1 | Drive data bus |
| chkOut | output | 8 | Check-bit bus, outgoing value |
| chkOe | output | 1 | Drive check-bit bus |
| oeN | output | 1 | Output enable, active low |
| readOut | output | 1 | Read in progress |
| writeN | output | 1 | Write strobe, active low |
| promSelN | output | 2 | PROM chip selects, active low |
| ramSelN | output | 5 | RAM bank chip selects, active low |
| ramOeN | output | 5 | RAM bank output enables, active low |
| byteWeN | output | 4 | Byte write strobes, active low |

## Verification
Every strobe comes from the phase state and the latched request, so a wrong phase state appears at the pins in the same cycle. Examples are a write strobe in the setup cycle, a select lingering into idle, or a done flag while bus-ready is high. A wrong latched address or wrong area flags show up at once as the wrong chip select, byte lane or check-bit enable in the first setup cycle. A lost address register shows up on `memAddr` in the first idle cycle after the access. The bench sweeps wait counts, both PROM halves, several banks including an unmapped one, and the 8-bit and EDAC flags.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } busState_t;

  typedef struct packed {
    logic load;
    logic selActive;
    logic rdPhase;
    logic wrStrobe;
    logic drive;
  } busCtl_t;
endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
  import membus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    busRdyN,
  output logic    reqReady,
  output logic    rspDone,
  output busCtl_t ctl
);
  busState_t state, nextState;
  logic      wrQ;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (reqValid) nextState = ST_SETUP;
      ST_SETUP:  nextState = ST_STROBE;
      ST_STROBE: if (!busRdyN) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wrQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && reqValid) wrQ <= reqWrite;
    end
  end

  always_comb begin
    reqReady      = (state == ST_IDLE);
    rspDone       = (state == ST_STROBE) && !busRdyN;
    ctl.load      = (state == ST_IDLE) && reqValid;
    ctl.selActive = (state != ST_IDLE);
    ctl.rdPhase   = ctl.selActive && !wrQ;
    ctl.wrStrobe  = (state == ST_STROBE) && wrQ;
    ctl.drive     = ctl.selActive && wrQ;
  end

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && busRdyN) |=> (state == ST_STROBE));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> reqReady);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/membus_dp.sv
module membus_dp
  import membus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_ADDR_W = 28,
  parameter int DATA_W     = 32,
  parameter int CHK_W      = 7,
  parameter int RAM_BANKS  = 5,
  parameter int BANK_LSB   = 24,
  parameter int PROM_SPLIT = 28
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busCtl_t               ctl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  input  logic [CHK_W-1:0]      reqCheck,
  input  logic                  prom8Bit,
  input  logic                  promEdac,
  input  logic [RAM_BANKS-1:0]  ram8Bit,
  input  logic [RAM_BANKS-1:0]  ramEdac,
  input  logic                  chkBit7,
  input  logic [DATA_W-1:0]     memDataIn,
  output logic [DATA_W-1:0]     rspData,
  output logic [BUS_ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]     memDataOut,
  output logic                  memDataOe,
  output logic [CHK_W:0]        chkOut,
  output logic                  chkOe,
  output logic                  oeN,
  output logic                  readOut,
  output logic                  writeN,
  output logic [1:0]            promSelN,
  output logic [RAM_BANKS-1:0]  ramSelN,
  output logic [RAM_BANKS-1:0]  ramOeN,
  output logic [DATA_W/8-1:0]   byteWeN
);
  localparam int LANES  = DATA_W / 8;
  localparam int BANK_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [CHK_W-1:0]  checkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      checkQ <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      checkQ <= reqCheck;
    end
  end

  logic                 isProm, isRam, is8, isEdac;
  logic [BANK_W-1:0]    bankIdx;
  logic [RAM_BANKS-1:0] bankHit;
  logic [LANES-1:0]     laneEn;

  assign isProm  = (addrQ[ADDR_W-1 -: 3] == 3'b000);
  assign isRam   = (addrQ[ADDR_W-1 -: 3] == 3'b010);
  assign bankIdx = addrQ[BANK_LSB +: BANK_W];

  for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
    assign bankHit[b] = isRam && (bankIdx == BANK_W'(b));
    assign ramSelN[b] = !(ctl.selActive && bankHit[b]);
    assign ramOeN[b]  = !(ctl.rdPhase && bankHit[b]);
  end

  assign is8    = (isProm && prom8Bit) || |(bankHit & ram8Bit);
  assign isEdac = (isProm && promEdac) || |(bankHit & ramEdac);

  assign promSelN[0] = !(ctl.selActive && isProm && !addrQ[PROM_SPLIT]);
  assign promSelN[1] = !(ctl.selActive && isProm &&  addrQ[PROM_SPLIT]);

  assign laneEn = is8 ? {{(LANES-1){1'b0}}, |beQ} : beQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign byteWeN[l] = !(ctl.wrStrobe && laneEn[l]);
  end

  assign memAddr    = addrQ[BUS_ADDR_W-1:0];
  assign memDataOut = wdataQ;
  assign memDataOe  = ctl.drive;
  assign chkOut     = {chkBit7, checkQ};
  assign chkOe      = ctl.drive && isEdac;
  assign oeN        = !ctl.rdPhase;
  assign readOut    = ctl.rdPhase;
  assign writeN     = !ctl.wrStrobe;
  assign rspData    = is8 ? {memDataIn[DATA_W-1 -: 8], {(DATA_W-8){1'b0}}} : memDataIn;

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~promSelN, ~ramSelN}));

  // R4
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeN |-> (oeN && !readOut && memDataOe));

  // R9
  chk_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkOe |-> memDataOe);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.selActive && !ctl.load) |=> $stable(memAddr));
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int RAM_BANKS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [31:0]          reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [3:0]           reqBe,
  input  logic [6:0]           reqCheck,
  output logic                 rspDone,
  output logic [31:0]          rspData,
  input  logic                 prom8Bit,
  input  logic                 promEdac,
  input  logic [RAM_BANKS-1:0] ram8Bit,
  input  logic [RAM_BANKS-1:0] ramEdac,
  input  logic                 chkBit7,
  input  logic                 busRdyN,
  output logic [27:0]          memAddr,
  output logic [31:0]          memDataOut,
  input  logic [31:0]          memDataIn,
  output logic                 memDataOe,
  output logic [7:0]           chkOut,
  output logic                 chkOe,
  output logic                 oeN,
  output logic                 readOut,
  output logic                 writeN,
  output logic [1:0]           promSelN,
  output logic [RAM_BANKS-1:0] ramSelN,
  output logic [RAM_BANKS-1:0] ramOeN,
  output logic [3:0]           byteWeN
);
  busCtl_t ctl;

  membus_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busRdyN(busRdyN), .reqReady(reqReady), .rspDone(rspDone), .ctl(ctl)
  );

  membus_dp #(.RAM_BANKS(RAM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqCheck(reqCheck),
    .prom8Bit(prom8Bit), .promEdac(promEdac), .ram8Bit(ram8Bit), .ramEdac(ramEdac),
    .chkBit7(chkBit7), .memDataIn(memDataIn), .rspData(rspData),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .chkOut(chkOut), .chkOe(chkOe), .oeN(oeN), .readOut(readOut), .writeN(writeN),
    .promSelN(promSelN), .ramSelN(ramSelN), .ramOeN(ramOeN), .byteWeN(byteWeN)
  );
endmodule

// File: tb/membus_ctrl_test.sv
`timescale 1ns/1ps
module membus_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic [6:0]  reqCheck = '0;
  logic        prom8Bit = 1'b0, promEdac = 1'b0, chkBit7 = 1'b1;
  logic [4:0]  ram8Bit = 5'b01000, ramEdac = 5'b00100;
  logic        busRdyN = 1'b1;
  logic [31:0] memDataIn = '0;
  logic        reqReady, rspDone, memDataOe, chkOe, oeN, readOut, writeN;
  logic [31:0] rspData, memDataOut;
  logic [27:0] memAddr;
  logic [7:0]  chkOut;
  logic [1:0]  promSelN;
  logic [4:0]  ramSelN, ramOeN;
  logic [3:0]  byteWeN;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  membus_ctrl uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input logic [6:0] code, input int waits,
                        input logic [31:0] din, input logic [1:0] expProm,
                        input logic [4:0] expRam, input logic [3:0] expWe,
                        input logic expChk, input logic [31:0] expRd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = wd; reqBe = be; reqCheck = code;
    #1 chk("R1 ready idle", reqReady, 1);
    @(negedge clk);
    reqValid = 0;
    #1;
    chk("R1 busy", reqReady, 0);
    chk("R5 prom sel setup", promSelN, expProm);
    chk("R6 ram sel setup", ramSelN, expRam);
    chk("R6 ram oe setup", ramOeN, wr ? 5'h1f : expRam);
    chk("R3 oeN setup", oeN, wr);
    chk("R3 read setup", readOut, !wr);
    chk("R4 no strobe in setup", writeN, 1);
    chk("R7 no byte strobe in setup", byteWeN, 4'hf);
    chk("R4 data oe", memDataOe, wr);
    if (wr) chk("R4 data value", memDataOut, wd);
    chk("R9 chk oe", chkOe, expChk);
    if (expChk) chk("R9 chk value", chkOut, {1'b1, code});
    chk("R10 addr", memAddr, addr[27:0]);
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);
      busRdyN = (k < waits); memDataIn = din;
      #1;
      chk("R2 strobe phase writeN", writeN, !wr);
      chk("R7 byte strobes", byteWeN, wr ? expWe : 4'hf);
      chk("R2 done timing", rspDone, k == waits);
      chk("R5 prom sel strobe", promSelN, expProm);
      if (k == waits && !wr) chk("R3 R8 read data", rspData, expRd);
    end
    @(negedge clk);
    busRdyN = 1;
    #1;
    chk("R2 back idle", reqReady, 1);
    chk("R5 prom sel idle", promSelN, 2'b11);
    chk("R6 ram sel idle", ramSelN, 5'h1f);
    chk("R3 oeN idle", oeN, 1);
    chk("R4 writeN idle", writeN, 1);
    chk("R4 data oe idle", memDataOe, 0);
    chk("R9 chk oe idle", chkOe, 0);
    chk("R10 addr hold", memAddr, addr[27:0]);
  endtask

  task automatic testReset();
    chk("R11 ready", reqReady, 1);
    chk("R11 prom sel", promSelN, 2'b11);
    chk("R11 ram sel", ramSelN, 5'h1f);
    chk("R11 ram oe", ramOeN, 5'h1f);
    chk("R11 oeN", oeN, 1);
    chk("R11 read", readOut, 0);
    chk("R11 writeN", writeN, 1);
    chk("R11 byte we", byteWeN, 4'hf);
    chk("R11 data oe", memDataOe, 0);
    chk("R11 chk oe", chkOe, 0);
    chk("R11 addr", memAddr, 0);
  endtask

  task automatic testPromLow();  // R5 lower half, R3 read, no wait
    access(0, 32'h0000_1234, 0, 0, 0, 0, 32'hA5C3_1E77, 2'b10, 5'h1f, 4'hf, 0, 32'hA5C3_1E77);
  endtask

  task automatic testPromHigh(); // R5 upper half, R2 waits
    access(0, 32'h1000_0040, 0, 0, 0, 2, 32'h0BAD_F00D, 2'b01, 5'h1f, 4'hf, 0, 32'h0BAD_F00D);
  endtask

  task automatic testRamEdacWrite(); // R6 bank 2, R9, R7 full word
    access(1, 32'h4200_0010, 32'hDEAD_BEEF, 4'hf, 7'h5A, 1, 0, 2'b11, 5'b11011, 4'h0, 1, 0);
  endtask

  task automatic testRamByteWrite(); // R7 lane 1, bank 0 not EDAC
    access(1, 32'h4000_0104, 32'h1234_5678, 4'b0010, 7'h11, 0, 0, 2'b11, 5'b11110, 4'b1101, 0, 0);
  endtask

  task automatic testRam8Read(); // R8 bank 3
    access(0, 32'h4300_0003, 0, 0, 0, 1, 32'h9C11_2233, 2'b11, 5'b10111, 4'hf, 0, 32'h9C00_0000);
  endtask

  task automatic testRam8Write(); // R8 only lane 0
    access(1, 32'h4300_0002, 32'h7700_0000, 4'b0100, 0, 0, 0, 2'b11, 5'b10111, 4'b1110, 0, 0);
  endtask

  task automatic testUnmappedBank(); // R6 bank 6 selects nothing
    access(0, 32'h4600_0000, 0, 0, 0, 0, 32'h0000_00FF, 2'b11, 5'h1f, 4'hf, 0, 32'h0000_00FF);
  endtask

  task automatic testPromEdacWrite(); // R9 PROM flag, R7 lane 3
    promEdac = 1;
    access(1, 32'h0000_0800, 32'h0000_00AB, 4'b1000, 7'h33, 3, 0, 2'b10, 5'h1f, 4'b0111, 1, 0);
    promEdac = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5 testReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    testPromLow();
    testPromHigh();
    testRamEdacWrite();
    testRamByteWrite();
    testRam8Read();
    testRam8Write();
    testUnmappedBank();
    testPromEdacWrite();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule